// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Fall-Through Option

This block is a single-clock first-in first-out buffer. It offers two read timings and a rewind feature. In standard timing, a word reaches the output register only when the consumer asserts read enable. In fall-through timing, the output register fills on its own whenever it is vacant and storage holds a word, so the head of the queue is always waiting on the bus. While master reset is held, two configuration pins choose the timing and the rewind latency. A partial reset empties the buffer and leaves both choices as they were.

A retransmit request moves the read side back to physical location zero, so every word written since the last reset can be read again. With zero-latency rewind, the first word is in the output register on the same edge that accepted the request. With normal latency, the output register loads it one edge later. Two status outputs keep one meaning in both timings. `avail` tells the consumer that a read will return data: in standard timing it means storage is not empty, and in fall-through timing it means the output register holds a valid word. `space` tells the producer that a write will be accepted. A third output, `half_full`, shows when the buffer holds more than half its depth.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst_n` is low, `cfg_fall_through` (1 = fall-through, 0 = standard) and `cfg_rt_normal` (1 = normal latency, 0 = zero latency) are captured. After master reset, `avail`=0, `space`=1, `half_full`=0 and `rd_data`=0.
- R2: In standard timing, `rd_en` high at an edge while storage is not empty places the oldest word on `rd_data` after that edge. Words leave in write order, and `avail` is high exactly when storage holds a word.
- R3: In standard timing, `rd_data` does not change on edges where `rd_en` is low and no rewind happens.
- R4: In fall-through timing, a word written at edge k into an empty buffer appears on `rd_data` with `avail`=1 after edge k+1, with no `rd_en`. After edge k, `avail` is still 0.
- R5: In fall-through timing, the words after the head need `rd_en`. `rd_en` high at an edge with `avail`=1 replaces `rd_data` with the next word, and without it the head stays.
- R6: `space` is low while storage holds DEPTH words. A write while `space` is low is dropped, and the stored contents and order do not change.
- R7: A standard-timing read while storage is empty leaves `rd_data` and the read position unchanged, so the next written word is the next one read.
- R8: `half_full` is high exactly when the occupancy exceeds DEPTH/2. In fall-through timing, occupancy counts the word held in the output register.
- R9: With zero-latency rewind, a `rt_req` edge (after at least one write) puts the word from location zero on `rd_data`. The next read returns the word from location one.
- R10: With normal-latency rewind, the request edge clears `avail` in fall-through timing. The next edge loads the word from location zero into `rd_data` and ignores `rd_en` on that edge.
- R11: `prst_n` low at an edge empties the buffer (`avail`=0, `space`=1, `half_full`=0) and keeps the captured timing and rewind latency.
- R12: `rt_req` has priority over `rd_en` on the same edge. The result is the rewind alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_fall_through | input | 1 | Timing select captured during master reset (1 = fall-through) |
| cfg_rt_normal | input | 1 | Rewind latency captured during master reset (1 = normal, 0 = zero) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Rewind request |
| rd_data | output | DW | Output register |
| avail | output | 1 | Read will return data (not empty / output ready) |
| space | output | 1 | Write will be accepted (not full / input ready) |
| half_full | output | 1 | Occupancy above DEPTH/2 |

## Verification
The assertions assume that a rewind is only requested when no more than DEPTH words have been written since the last reset. Past that point the pointer arithmetic no longer describes the rewound contents. The assertions also assume that the configuration pins are only meaningful while master reset is low. The stimulus follows both assumptions: each rewind comes after at most DEPTH writes following a master or partial reset, and the configuration pins change only inside a master reset. Overfull writes and reads from an empty buffer are deliberately included, because the block must absorb them without disturbing its pointers.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

  typedef enum logic {
    TM_STANDARD = 1'b0,
    TM_FALLTHRU = 1'b1
  } tmode_e;

  typedef enum logic {
    RT_ZERO   = 1'b0,
    RT_NORMAL = 1'b1
  } rtlat_e;

  typedef struct packed {
    tmode_e tmode;
    rtlat_e rtlat;
  } fifo_cfg_t;

  // Distance from tail to head on a ring of 2**bits positions.
  function automatic logic [31:0] ring_gap(logic [31:0] head, logic [31:0] tail,
                                           int unsigned bits);
    logic [31:0] mask;
    mask = (32'd1 << bits) - 32'd1;
    return (head - tail) & mask;
  endfunction

  // Words held: storage plus, in fall-through timing, the output register.
  function automatic logic [31:0] held_words(logic [31:0] stored, logic out_full,
                                             tmode_e tm);
    return stored + ((tm == TM_FALLTHRU && out_full) ? 32'd1 : 32'd0);
  endfunction

  function automatic logic above_half(logic [31:0] lvl, int unsigned depth);
    return lvl > 32'(depth >> 1);
  endfunction

endpackage

// File: rtl/rewind_fifo_cfg.sv
module rewind_fifo_cfg
  import rewind_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      mrst_n,
  input  logic      pin_fall_through,
  input  logic      pin_rt_normal,
  output fifo_cfg_t cfg
);

  // Captured only while master reset is held; partial reset does not touch it.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg.tmode <= tmode_e'(pin_fall_through);
      cfg.rtlat <= rtlat_e'(pin_rt_normal);
    end
  end

endmodule

// File: rtl/rewind_fifo_store.sv
module rewind_fifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          full,
  input  logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] wr_ptr,
  output logic          wr_fire,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] head_word
);

  logic [DW-1:0] mem [DEPTH];

  assign wr_fire   = wr_en && !full;
  assign rd_word   = mem[rd_ptr[AW-1:0]];
  assign head_word = mem[0];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) wr_ptr <= '0;
    else if (wr_fire)       wr_ptr <= wr_ptr + PW'(1);
  end

  // R6: a write attempted while full leaves the write pointer where it was
  assert_full_write_dropped_R6: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (wr_en && full) |=> $stable(wr_ptr));

endmodule

// File: rtl/rewind_fifo_rdctl.sv
module rewind_fifo_rdctl
  import rewind_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  fifo_cfg_t     cfg,
  input  logic          rd_en,
  input  logic          rt_req,
  input  logic [PW-1:0] stored,
  input  logic          wrote_any,
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] head_word,
  output logic [PW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic          rt_pend
);

  logic ft_mode, have_word, ft_load, std_read, rt_zero_load;

  assign ft_mode      = (cfg.tmode == TM_FALLTHRU);
  assign have_word    = (stored != '0);
  assign ft_load      = ft_mode && have_word && (!out_valid || rd_en);
  assign std_read     = !ft_mode && rd_en && have_word;
  assign rt_zero_load = (cfg.rtlat == RT_ZERO) && wrote_any;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      rd_ptr    <= '0;
      rd_data   <= '0;
      out_valid <= 1'b0;
      rt_pend   <= 1'b0;
    end else if (rt_req) begin
      if (rt_zero_load) begin
        rd_ptr    <= PW'(1);
        rd_data   <= head_word;
        out_valid <= 1'b1;
        rt_pend   <= 1'b0;
      end else begin
        rd_ptr    <= '0;
        out_valid <= 1'b0;
        rt_pend   <= (cfg.rtlat == RT_NORMAL);
      end
    end else if (rt_pend) begin
      rt_pend <= 1'b0;
      if (have_word) begin
        rd_data   <= rd_word;
        rd_ptr    <= rd_ptr + PW'(1);
        out_valid <= 1'b1;
      end
    end else if (ft_mode) begin
      if (ft_load) begin
        rd_data   <= rd_word;
        rd_ptr    <= rd_ptr + PW'(1);
        out_valid <= 1'b1;
      end else if (rd_en && out_valid) begin
        out_valid <= 1'b0;
      end
    end else if (std_read) begin
      rd_data <= rd_word;
      rd_ptr  <= rd_ptr + PW'(1);
    end
  end

  // R2: a standard read shows the word the store presented at that edge
  assert_std_read_word_R2: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (!ft_mode && rd_en && have_word && !rt_req && !rt_pend)
      |=> (rd_data == $past(rd_word)));

  // R7: a standard read from empty storage moves nothing
  assert_empty_read_ignored_R7: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (!ft_mode && rd_en && !have_word && !rt_req && !rt_pend)
      |=> ($stable(rd_ptr) && $stable(rd_data)));

  // R4: a vacant output register in fall-through timing fills on the next edge
  assert_fall_through_fill_R4: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (ft_mode && !out_valid && have_word && !rt_req && !rt_pend) |=> out_valid);

  // R9: zero-latency rewind presents location zero on the request edge
  assert_rewind_zero_R9: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (rt_req && cfg.rtlat == RT_ZERO && wrote_any)
      |=> (rd_data == $past(head_word) && rd_ptr == PW'(1)));

  // R10: normal-latency rewind parks at location zero with the output empty
  assert_rewind_normal_R10: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    (rt_req && cfg.rtlat == RT_NORMAL) |=> (rd_ptr == '0 && !out_valid && rt_pend));

  // R11: partial reset returns the read side to the start
  assert_partial_reset_R11: assert property (@(posedge clk)
    disable iff (!mrst_n)
    (!prst_n) |=> (rd_ptr == '0 && !out_valid && !rt_pend));

endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags
  import rewind_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  fifo_cfg_t     cfg,
  input  logic [PW-1:0] stored,
  input  logic          out_valid,
  output logic          full,
  output logic          avail,
  output logic          space,
  output logic          half_full
);

  logic [31:0] level;

  assign level     = held_words(32'(stored), out_valid, cfg.tmode);
  assign full      = (stored == PW'(DEPTH));
  assign space     = !full;
  assign avail     = (cfg.tmode == TM_FALLTHRU) ? out_valid : (stored != '0);
  assign half_full = above_half(level, DEPTH);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          cfg_fall_through,
  input  logic          cfg_rt_normal,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rt_req,
  output logic [DW-1:0] rd_data,
  output logic          avail,
  output logic          space,
  output logic          half_full
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  fifo_cfg_t     cfg;
  logic [PW-1:0] wr_ptr, rd_ptr, stored;
  logic [DW-1:0] rd_word, head_word;
  logic          wr_fire, full, out_valid, rt_pend, wrote_any;

  assign stored    = PW'(ring_gap(32'(wr_ptr), 32'(rd_ptr), PW));
  assign wrote_any = (wr_ptr != '0);

  rewind_fifo_cfg u_cfg (
    .clk              (clk),
    .mrst_n           (mrst_n),
    .pin_fall_through (cfg_fall_through),
    .pin_rt_normal    (cfg_rt_normal),
    .cfg              (cfg)
  );

  rewind_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .full      (full),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .wr_fire   (wr_fire),
    .rd_word   (rd_word),
    .head_word (head_word)
  );

  rewind_fifo_rdctl #(.DW(DW), .DEPTH(DEPTH)) u_rdctl (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .cfg       (cfg),
    .rd_en     (rd_en),
    .rt_req    (rt_req),
    .stored    (stored),
    .wrote_any (wrote_any),
    .rd_word   (rd_word),
    .head_word (head_word),
    .rd_ptr    (rd_ptr),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .rt_pend   (rt_pend)
  );

  rewind_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .cfg       (cfg),
    .stored    (stored),
    .out_valid (out_valid),
    .full      (full),
    .avail     (avail),
    .space     (space),
    .half_full (half_full)
  );

  // R6: storage never holds more than DEPTH words
  assert_no_overflow_R6: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    stored <= PW'(DEPTH));

  // R8: the half-full flag can only rise after an accepted write or a rewind
  assert_half_rise_cause_R8: assert property (@(posedge clk)
    disable iff (!mrst_n || !prst_n)
    $rose(half_full) |-> ($past(wr_fire) || $past(rt_req)));

endmodule

// File: tb/tb_rewind_fifo.sv
module tb_rewind_fifo;
  localparam int DW    = 16;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          mrst_n, prst_n, cfg_fall_through, cfg_rt_normal;
  logic          wr_en, rd_en, rt_req;
  logic [DW-1:0] wr_data, rd_data;
  logic          avail, space, half_full;

  always #5 clk = ~clk;

  rewind_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_fall_through(cfg_fall_through), .cfg_rt_normal(cfg_rt_normal),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_req(rt_req),
    .rd_data(rd_data), .avail(avail), .space(space), .half_full(half_full)
  );

  int            checks = 0;
  int            errors = 0;
  bit            ft_mode;
  logic [DW-1:0] sb[$];    // scoreboard: words expected to leave, oldest first
  logic [DW-1:0] hist[$];  // every accepted word since the last reset
  logic [DW-1:0] last_out;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic master_reset(input bit ft, input bit rtn);
    mrst_n = 1'b0; cfg_fall_through = ft; cfg_rt_normal = rtn;
    tick; tick;
    mrst_n = 1'b1; cfg_fall_through = ~ft; cfg_rt_normal = ~rtn;
    ft_mode = ft; sb.delete(); hist.delete(); last_out = '0;
  endtask

  task automatic partial_reset;
    prst_n = 1'b0; tick; prst_n = 1'b1;
    sb.delete(); hist.delete(); last_out = '0;
  endtask

  // driver: pushes the word into the scoreboard when the model accepts it
  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    if (ft_mode || sb.size() < DEPTH) begin
      sb.push_back(d); hist.push_back(d);
    end
    tick;
    wr_en = 1'b0;
  endtask

  // standard-timing read: pops the expected word and compares the output
  task automatic pull_std(input string req);
    logic [DW-1:0] e;
    rd_en = 1'b1; tick; rd_en = 1'b0;
    if (sb.size() != 0) e = sb.pop_front();
    else e = last_out;
    last_out = e;
    check(rd_data == e, req, rd_data, e);
  endtask

  // fall-through read: consumes the head, the next word follows on the same edge
  task automatic pull_ft(input string req);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    void'(sb.pop_front());
    check(avail == (sb.size() != 0), req, avail, sb.size() != 0);
    if (sb.size() != 0) check(rd_data == sb[0], req, rd_data, sb[0]);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    prst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; rt_req = 1'b0; wr_data = '0;
    @(negedge clk);

    // ---------------- standard timing, zero-latency rewind
    master_reset(1'b0, 1'b0);
    check(avail == 1'b0, "R1 avail", avail, 0);
    check(space == 1'b1, "R1 space", space, 1);
    check(half_full == 1'b0, "R1 half_full", half_full, 0);
    check(rd_data == '0, "R1 rd_data", rd_data, 0);

    push(16'h1111); push(16'h2222); push(16'h3333);
    check(avail == 1'b1, "R2 avail with data", avail, 1);
    check(rd_data == '0, "R3 no read no output", rd_data, 0);
    pull_std("R2 first read");
    tick; tick;
    check(rd_data == 16'h1111, "R3 hold while idle", rd_data, 16'h1111);
    pull_std("R2 second read");
    pull_std("R2 third read");
    check(avail == 1'b0, "R2 empty after drain", avail, 0);
    pull_std("R7 read from empty holds");
    push(16'h4444);
    pull_std("R7 next word after empty read");

    partial_reset;
    check(avail == 1'b0, "R11 std avail", avail, 0);
    check(space == 1'b1, "R11 std space", space, 1);
    for (int i = 1; i <= DEPTH; i++) begin
      push(16'hA000 + 16'(i - 1));
      check(half_full == (i > DEPTH / 2), "R8 std level", half_full, i > DEPTH / 2);
      check(space == (i < DEPTH), "R6 space", space, i < DEPTH);
    end
    push(16'hBAD0);
    check(space == 1'b0, "R6 still full", space, 0);
    for (int i = 0; i < DEPTH; i++) pull_std("R6 order after dropped write");
    check(avail == 1'b0, "R6 drained", avail, 0);

    // rewind with rd_en on the same edge
    rt_req = 1'b1; rd_en = 1'b1; tick; rt_req = 1'b0; rd_en = 1'b0;
    check(rd_data == hist[0], "R9 R12 zero-latency word", rd_data, hist[0]);
    check(avail == 1'b1, "R12 rewound data remains", avail, 1);
    sb = hist; void'(sb.pop_front());
    pull_std("R9 continues at second word");

    // ---------------- fall-through timing, normal-latency rewind
    master_reset(1'b1, 1'b1);
    check(avail == 1'b0, "R1 ft avail", avail, 0);
    check(space == 1'b1, "R1 ft space", space, 1);
    push(16'h5001);
    check(avail == 1'b0, "R4 not yet after write edge", avail, 0);
    tick;
    check(avail == 1'b1, "R4 ready one edge later", avail, 1);
    check(rd_data == 16'h5001, "R4 first word falls through", rd_data, 16'h5001);
    push(16'h5002); push(16'h5003);
    check(rd_data == 16'h5001, "R5 head waits for rd_en", rd_data, 16'h5001);
    pull_ft("R5 next word on rd_en");

    partial_reset;
    check(avail == 1'b0, "R11 ft avail", avail, 0);
    check(half_full == 1'b0, "R11 ft half_full", half_full, 0);
    for (int i = 1; i <= 9; i++) begin
      push(16'h6000 + 16'(i));
      check(half_full == (i > DEPTH / 2), "R8 ft level with output word",
            half_full, i > DEPTH / 2);
      if (i == 2)
        check(avail && rd_data == 16'h6001, "R11 fall-through kept", rd_data, 16'h6001);
    end
    pull_ft("R5 read two");
    pull_ft("R5 read three");

    rt_req = 1'b1; tick; rt_req = 1'b0;
    check(avail == 1'b0, "R10 output cleared on request", avail, 0);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    check(avail == 1'b1, "R10 ready one edge later", avail, 1);
    check(rd_data == hist[0], "R10 first word", rd_data, hist[0]);
    tick;
    check(rd_data == hist[0], "R10 rd_en ignored on load edge", rd_data, hist[0]);
    sb = hist;
    pull_ft("R10 continues after rewind");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule